// File: doc/BRIEF.md
# Phase-Selectable Integer Clock Divider

This block derives a slower clock from a fast input clock. It either passes the input clock straight through, or divides it by any whole number from 2 to 32. When a chip needs several outputs that keep a fixed skew to one another, it places one copy of the block per output. Each copy has its own start offset, counted in whole input cycles, and all copies share one active-low restart line. Releasing that line starts every copy from the same input edge, and each copy then waits its own number of input cycles before its first rising edge.

A divider that is not needed can be powered down, which parks its output low. The ratio may be changed while the divider is running. The new ratio is applied only when the current output period ends, so the output never shows a shortened pulse. A new start offset is applied only at the next restart.

Top module: `phase_clk_div`

## Requirements
- R1: With `bypass_i` high and `pwrdn_i` low, `clk_o` equals `clk_i` at every instant, whatever the value of `phase_i`.
- R2: With bypass off and a ratio N between 2 and 32, `clk_o` repeats with a period of exactly N input cycles.
- R3: In each period the output is high for (N+1)/2 input cycles (integer division) and low for the remaining cycles, so even ratios give a 50% duty cycle.
- R4: `ratio_i` is an unsigned 6-bit value. Values below 2 act as 2 and values above 32 act as 32.
- R5: The restart input `sync_ni` is sampled on rising edges of `clk_i`. Whenever it is seen low, `clk_o` is low from that edge on. A low pulse lasting 1.5 input cycles or longer always contains a rising edge and is therefore always taken. A low pulse that contains no rising edge has no effect on the output.
- R6: Call E0 the first rising edge at which `sync_ni` is seen high again. The first rising edge of the output comes exactly P input cycles after E0, where P is `phase_i` (unsigned, 5 bits) limited to at most N-1.
- R7: A change of `ratio_i` while the divider is running takes effect at the start of the next output period. A change of `phase_i` while running has no effect until the next restart.
- R8: While `pwrdn_i` is high, `clk_o` is low, including in bypass mode, and the divider is held as during a restart. Dropping `pwrdn_i` restarts the divider just as a release of `sync_ni` does.
- R9: Two copies that share the input clock, the ratio and the restart line, but are given start offsets Pa and Pb, have first rising edges Pb-Pa input cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Restart request, active low |
| pwrdn_i | input | 1 | Power-down: output parked low, divider held |
| bypass_i | input | 1 | Pass `clk_i` straight to the output |
| ratio_i | input | 6 | Divide ratio N, limited to 2..32 |
| phase_i | input | 5 | Start offset in input cycles, limited to N-1 |
| clk_o | output | 1 | Divided or bypassed clock |

## Verification
The bench builds two copies of the divider with the default limits of 2 and 32. This lets it sweep every ratio from 1 (bypass) to 32. For each ratio, one copy starts at offset N/2 and the other at the largest legal offset N-1, so each sweep step checks the output period, the high time and the spacing between the two copies. Separate scenarios feed ratio and offset values outside the legal range, change the ratio and the offset while the divider runs, and apply restart pulses that straddle a rising edge or fall between two edges. A power-down scenario also turns bypass on, to show that power-down still parks the output low.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  // Clamp a raw ratio code into the legal divide range.
  function automatic int fit_ratio(int raw, int lo, int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Start offset may not exceed one period minus one cycle.
  function automatic int fit_phase(int raw, int n);
    return (raw > n - 1) ? n - 1 : raw;
  endfunction

  // Number of high input cycles in one output period.
  function automatic int high_len(int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/pcd_start_ctl.sv
module pcd_start_ctl
  import pcd_pkg::*;
#(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 32,
  localparam int RW = $clog2(MAX_RATIO + 1),
  localparam int PW = $clog2(MAX_RATIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [PW-1:0] phase_i,
  output logic          started_o,
  output logic [PW-1:0] wait_o,
  output logic          launch_o
);

  logic [PW-1:0] wait_q;
  logic          started_q;
  int            n_eff;

  assign n_eff = fit_ratio(int'(ratio_i), MIN_RATIO, MAX_RATIO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q    <= '0;
      started_q <= 1'b0;
    end else if (hold_i) begin
      wait_q    <= PW'(fit_phase(int'(phase_i), n_eff));
      started_q <= 1'b0;
    end else if (!started_q) begin
      if (wait_q == '0) started_q <= 1'b1;
      else              wait_q    <= wait_q - 1'b1;
    end
  end

  assign launch_o  = !hold_i && !started_q && (wait_q == '0);
  assign started_o = started_q;
  assign wait_o    = wait_q;

endmodule

// File: rtl/pcd_period_ctr.sv
module pcd_period_ctr
  import pcd_pkg::*;
#(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 32,
  localparam int RW = $clog2(MAX_RATIO + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          launch_i,
  input  logic          started_i,
  input  logic [RW-1:0] ratio_i,
  output logic [RW-1:0] pos_o,
  output logic [RW-1:0] n_o,
  output logic          wrap_o,
  output logic          div_o
);

  logic [RW-1:0] pos_q;
  logic [RW-1:0] n_q;
  logic          div_q;
  logic [RW-1:0] nxt_pos;
  logic [RW-1:0] n_new;

  assign n_new   = RW'(fit_ratio(int'(ratio_i), MIN_RATIO, MAX_RATIO));
  assign nxt_pos = pos_q + 1'b1;
  assign wrap_o  = started_i && !hold_i && (pos_q == n_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      n_q   <= RW'(MIN_RATIO);
      div_q <= 1'b0;
    end else if (hold_i) begin
      pos_q <= '0;
      n_q   <= n_new;
      div_q <= 1'b0;
    end else if (launch_i) begin
      pos_q <= '0;
      div_q <= 1'b1;
    end else if (wrap_o) begin
      pos_q <= '0;
      n_q   <= n_new;
      div_q <= 1'b1;
    end else if (started_i) begin
      pos_q <= nxt_pos;
      div_q <= (int'(nxt_pos) < high_len(int'(n_q)));
    end else begin
      div_q <= 1'b0;
    end
  end

  assign pos_o = pos_q;
  assign n_o   = n_q;
  assign div_o = div_q;

endmodule

// File: rtl/pcd_out_sel.sv
module pcd_out_sel (
  input  logic clk_i,
  input  logic div_i,
  input  logic bypass_i,
  input  logic pwrdn_i,
  output logic clk_o
);

  always_comb begin
    if (pwrdn_i)       clk_o = 1'b0;
    else if (bypass_i) clk_o = clk_i;
    else               clk_o = div_i;
  end

endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 32,
  localparam int RW = $clog2(MAX_RATIO + 1),
  localparam int PW = $clog2(MAX_RATIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_ni,
  input  logic          pwrdn_i,
  input  logic          bypass_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [PW-1:0] phase_i,
  output logic          clk_o
);

  // Named internal events, also observed by the bound checker.
  logic          hold_req;
  logic          launch;
  logic          wrap;
  logic          started;
  logic [PW-1:0] wait_cnt;
  logic [RW-1:0] pos;
  logic [RW-1:0] n_cur;
  logic          div_q;

  assign hold_req = !sync_ni || pwrdn_i;

  pcd_start_ctl #(
    .MIN_RATIO(MIN_RATIO),
    .MAX_RATIO(MAX_RATIO)
  ) u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold_req),
    .ratio_i  (ratio_i),
    .phase_i  (phase_i),
    .started_o(started),
    .wait_o   (wait_cnt),
    .launch_o (launch)
  );

  pcd_period_ctr #(
    .MIN_RATIO(MIN_RATIO),
    .MAX_RATIO(MAX_RATIO)
  ) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold_req),
    .launch_i (launch),
    .started_i(started),
    .ratio_i  (ratio_i),
    .pos_o    (pos),
    .n_o      (n_cur),
    .wrap_o   (wrap),
    .div_o    (div_q)
  );

  pcd_out_sel u_out (
    .clk_i   (clk_i),
    .div_i   (div_q),
    .bypass_i(bypass_i),
    .pwrdn_i (pwrdn_i),
    .clk_o   (clk_o)
  );

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int MIN_RATIO = 2,
  parameter int MAX_RATIO = 32,
  localparam int RW = $clog2(MAX_RATIO + 1),
  localparam int PW = $clog2(MAX_RATIO)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_req,
  input logic          launch,
  input logic          wrap,
  input logic          started,
  input logic [PW-1:0] wait_cnt,
  input logic [RW-1:0] pos,
  input logic [RW-1:0] n_cur,
  input logic          div_q
);

  logic [7:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_run <= '0;
    else if (div_q) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  assert_hold_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_req |=> !div_q);

  assert_launch_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> div_q);

  assert_wait_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_req && !started && wait_cnt != '0) |=> !div_q);

  assert_pos_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (pos < n_cur));

  assert_wrap_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> div_q);

  assert_high_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= 8'((MAX_RATIO + 1) / 2));

  assert_ratio_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap && !hold_req) |=> $stable(n_cur));

  assert_ratio_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_cur >= RW'(MIN_RATIO)) && (n_cur <= RW'(MAX_RATIO)));

endmodule

bind phase_clk_div pcd_checker #(
  .MIN_RATIO(MIN_RATIO),
  .MAX_RATIO(MAX_RATIO)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hold_req(hold_req),
  .launch  (launch),
  .wrap    (wrap),
  .started (started),
  .wait_cnt(wait_cnt),
  .pos     (pos),
  .n_cur   (n_cur),
  .div_q   (div_q)
);

// File: tb/phase_clk_div_tb_top.sv
`timescale 1ns/1ps
module phase_clk_div_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic       pwrdn = 1'b0;
  logic       bypass = 1'b0;
  logic [5:0] ratio = 6'd4;
  logic [4:0] phase_a = '0;
  logic [4:0] phase_b = '0;
  logic       clk_a, clk_b;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  phase_clk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .pwrdn_i(pwrdn),
    .bypass_i(bypass), .ratio_i(ratio), .phase_i(phase_a), .clk_o(clk_a)
  );

  phase_clk_div dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .pwrdn_i(pwrdn),
    .bypass_i(bypass), .ratio_i(ratio), .phase_i(phase_b), .clk_o(clk_b)
  );

  // Expected level at sample k after the restart: nothing before the
  // offset, then a high stretch covering the first half (rounded up).
  function automatic bit exp_bit(int k, int n, int p);
    if (k < p) return 1'b0;
    return (2 * ((k - p) % n) < n);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
  endtask

  // R2 R3 R6 R9: two copies with different offsets
  task automatic run_pair(int n, int pa, int pb);
    int fa = -1;
    int fb = -1;
    int len = pb + 2 * n + 2;
    ratio = 6'(n); phase_a = 5'(pa); phase_b = 5'(pb); bypass = 1'b0;
    restart();
    for (int k = 0; k < len; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, n, pa), "R2 R3 R6 copy a", int'(clk_a), int'(exp_bit(k, n, pa)));
      check(clk_b == exp_bit(k, n, pb), "R2 R3 R6 copy b", int'(clk_b), int'(exp_bit(k, n, pb)));
      if (clk_a && fa < 0) fa = k;
      if (clk_b && fb < 0) fb = k;
    end
    check((fb - fa) == (pb - pa), "R9 edge spacing", fb - fa, pb - pa);
  endtask

  // R1: bypass follows the input clock, offsets ignored
  task automatic t_bypass();
    bypass = 1'b1; phase_a = 5'd3; phase_b = 5'd7;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      check(clk_a && clk_b, "R1 bypass high", int'(clk_a) + int'(clk_b), 2);
      @(negedge clk); #1;
      check(!clk_a && !clk_b, "R1 bypass low", int'(clk_a) + int'(clk_b), 0);
    end
    bypass = 1'b0;
  endtask

  task automatic t_sweep();
    for (int n = 1; n <= 32; n++) begin
      if (n == 1) t_bypass();
      else run_pair(n, n / 2, n - 1);
    end
  endtask

  task automatic run_single(int rraw, int praw, int n, int p, string req);
    ratio = 6'(rraw); phase_a = 5'(praw); bypass = 1'b0;
    restart();
    for (int k = 0; k < p + 2 * n + 2; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, n, p), req, int'(clk_a), int'(exp_bit(k, n, p)));
    end
  endtask

  // R4 R6: out-of-range ratio and offset codes
  task automatic t_clamp();
    run_single(0, 0, 2, 0, "R4 ratio 0 as 2");
    run_single(1, 1, 2, 1, "R4 ratio 1 as 2");
    run_single(45, 3, 32, 3, "R4 ratio 45 as 32");
    run_single(6, 20, 6, 5, "R6 offset limited to N-1");
  endtask

  // R5: pulse between edges ignored
  task automatic t_short_sync();
    ratio = 6'd4; phase_a = '0;
    restart();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, 4, 0), "R5 short pulse ignored", int'(clk_a), int'(exp_bit(k, 4, 0)));
      if (k == 6) begin
        sync_n = 1'b0; #2; sync_n = 1'b1;
      end
    end
  endtask

  // R5 R6: 1.5-cycle pulse mid-run is taken and restarts with offset
  task automatic t_long_sync();
    ratio = 6'd5; phase_a = 5'd2;
    restart();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, 5, 2), "R6 before pulse", int'(clk_a), int'(exp_bit(k, 5, 2)));
    end
    @(posedge clk); #2;
    sync_n = 1'b0;
    #14;
    check(clk_a == 1'b0, "R5 held low by 1.5-cycle pulse", int'(clk_a), 0);
    #1;
    sync_n = 1'b1;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, 5, 2), "R5 R6 restart after pulse", int'(clk_a), int'(exp_bit(k, 5, 2)));
    end
  endtask

  // R7: ratio change at period end, offset change waits for restart
  task automatic t_live_change();
    ratio = 6'd4; phase_a = '0;
    restart();
    for (int k = 0; k < 16; k++) begin
      bit e;
      @(negedge clk); #1;
      e = (k < 8) ? ((k % 4) < 2) : (((k - 8) % 6) < 3);
      check(clk_a == e, "R7 live ratio and offset change", int'(clk_a), int'(e));
      if (k == 5) begin
        ratio = 6'd6; phase_a = 5'd3;
      end
    end
  endtask

  // R8: power-down parks output, release restarts
  task automatic t_pwrdn();
    @(negedge clk);
    bypass = 1'b1; pwrdn = 1'b1;
    @(posedge clk); #2;
    check(clk_a == 1'b0, "R8 low in power-down with bypass", int'(clk_a), 0);
    @(negedge clk); #1;
    check(clk_a == 1'b0, "R8 low in power-down", int'(clk_a), 0);
    bypass = 1'b0; ratio = 6'd3; phase_a = 5'd1;
    @(negedge clk);
    pwrdn = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #1;
      check(clk_a == exp_bit(k, 3, 1), "R8 restart after power-down", int'(clk_a), int'(exp_bit(k, 3, 1)));
    end
  endtask

  initial begin
    #12;
    check(!clk_a && !clk_b, "reset output low", int'(clk_a) + int'(clk_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_sweep();
    t_clamp();
    t_short_sync();
    t_long_sync();
    t_live_change();
    t_pwrdn();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule